// File: doc/BRIEF.md
# Delimited Hex Text Image Loader

This block takes the ASCII text of a program image one byte at a time over a valid/ready handshake. It turns that text into 16-bit words and writes them into a program memory through a simple address, data and write-enable port. The payload sits between an opening pair of left braces and a closing pair of right braces. Any text before the opening pair or after the closing pair is commentary and is thrown away. Inside the frame, only hexadecimal digit characters carry data. Spaces, punctuation and any other byte are passed over.

The loader packs every run of four digits into one word and writes the words to ascending addresses from zero. A one-cycle end-of-input pulse ends the load. The block then raises a sticky done flag. It sets an error flag with it if the frame was never opened, never closed, or holds a digit count that is not a multiple of four. After done the loader stops taking bytes until it is reset.

Top module: `hexframe_loader`

## Requirements
- R1: After reset, load_done, load_err and mem_we are 0 and in_ready is 1.
- R2: Bytes before the frame opens are ignored. Two consecutive `{` bytes (0x7B) open the frame. A lone `{` or `}` followed by any other byte is not a delimiter, and the byte after it is handled as if no brace had come before it.
- R3: Inside the frame, bytes 0x30–0x39 give digit values 0–9, 0x41–0x46 give 10–15, and (when ACCEPT_LOWER is 1, the default) 0x61–0x66 give 10–15. Every other byte is skipped and does not count as a digit.
- R4: Each group of four digits forms one word, with the first digit in bits 15:12 and the fourth in bits 3:0. The word appears on mem_wdata with mem_we high for exactly one cycle, in the cycle after the handshake that delivered the fourth digit.
- R5: Successive words are written to mem_addr 0, 1, 2, … in arrival order.
- R6: Two consecutive `}` bytes (0x7D) close the frame. Any bytes accepted after that are discarded and cause no write.
- R7: An eoi pulse while load_done is 0 sets load_done in the next cycle. load_done then stays 1 until reset, in_ready is 0, and further bytes and eoi pulses have no effect.
- R8: load_err is set together with load_done when the frame was never opened or was opened but never closed.
- R9: load_err is set together with load_done when the number of digits inside the frame is not a multiple of four. The complete words before the leftover digits are still written.
- R10: No write happens in any cycle after the first cycle in which load_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A text byte is offered on in_byte |
| in_byte | input | 8 | ASCII text byte |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| eoi | input | 1 | One-cycle end-of-input pulse |
| mem_we | output | 1 | Write strobe for program memory |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | WORD_W | Packed word being written |
| load_done | output | 1 | Loading finished (sticky) |
| load_err | output | 1 | Image was malformed; valid with load_done |

## Verification
The assertions assume that eoi is a single-cycle pulse, and that no more words arrive than ADDR_W can address, so the write address never wraps. They also assume eoi is never raised in the same cycle as a byte handshake. The bench keeps eoi low while it streams bytes, pulses it once in a quiet cycle, and uses images of at most a few words. After done it holds in_valid high with ready low and pulses eoi again, to show that the sticky state cannot be disturbed.

// File: rtl/hfl_pkg.sv
package hfl_pkg;

   typedef enum logic [2:0] {
      FR_OUTSIDE  = 3'd0,
      FR_OPENING  = 3'd1,
      FR_INSIDE   = 3'd2,
      FR_CLOSING  = 3'd3,
      FR_FINISHED = 3'd4
   } frame_st_e;

   localparam logic [7:0] CH_LBRACE = 8'h7B;
   localparam logic [7:0] CH_RBRACE = 8'h7D;

endpackage

// File: rtl/hfl_char_decode.sv
module hfl_char_decode #(
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic [3:0] nib,
   output logic       is_lbrace,
   output logic       is_rbrace
);
   import hfl_pkg::*;

   logic       dec_ok, upr_ok, low_ok;
   logic [3:0] dec_v, upr_v, low_v;

   always_comb begin
      dec_ok = (ch >= 8'h30) && (ch <= 8'h39);
      upr_ok = (ch >= 8'h41) && (ch <= 8'h46);
      dec_v  = 4'(ch - 8'h30);
      upr_v  = 4'(ch - 8'h37);
      low_v  = 4'(ch - 8'h57);
   end

   generate
      if (ACCEPT_LOWER) begin : g_lower_on
         assign low_ok = (ch >= 8'h61) && (ch <= 8'h66);
      end else begin : g_lower_off
         assign low_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      is_hex = dec_ok | upr_ok | low_ok;
      if (dec_ok)      nib = dec_v;
      else if (upr_ok) nib = upr_v;
      else if (low_ok) nib = low_v;
      else             nib = 4'h0;
   end

   assign is_lbrace = (ch == CH_LBRACE);
   assign is_rbrace = (ch == CH_RBRACE);

endmodule

// File: rtl/hfl_frame_tracker.sv
module hfl_frame_tracker (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic                is_lbrace,
   input  logic                is_rbrace,
   output hfl_pkg::frame_st_e  st_q,
   output hfl_pkg::frame_st_e  st_d,
   output logic                inside_q,
   output logic                data_ok
);
   import hfl_pkg::*;

   always_comb begin
      st_d = st_q;
      if (step) begin
         unique case (st_q)
            FR_OUTSIDE:  if (is_lbrace) st_d = FR_OPENING;
            FR_OPENING:  st_d = is_lbrace ? FR_INSIDE : FR_OUTSIDE;
            FR_INSIDE:   if (is_rbrace) st_d = FR_CLOSING;
            FR_CLOSING:  st_d = is_rbrace ? FR_FINISHED : FR_INSIDE;
            FR_FINISHED: st_d = FR_FINISHED;
            default:     st_d = FR_OUTSIDE;
         endcase
      end
   end

   assign inside_q = (st_q == FR_INSIDE) || (st_q == FR_CLOSING);
   assign data_ok  = step && inside_q && !is_rbrace;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FR_OUTSIDE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/hfl_word_packer.sv
module hfl_word_packer #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dig_vld,
   input  logic [3:0]        dig,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] wdata,
   output logic              partial_d
);
   localparam int NIB   = WORD_W / 4;
   localparam int CNT_W = $clog2(NIB);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NIB - 1);

   logic [WORD_W-1:0] acc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] wptr_q;
   logic [WORD_W-1:0] acc_nx;

   assign acc_nx    = {acc_q[WORD_W-5:0], dig};
   assign partial_d = dig_vld ? (cnt_q != LAST) : (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         wptr_q <= '0;
         we     <= 1'b0;
         addr   <= '0;
         wdata  <= '0;
      end else begin
         we <= 1'b0;
         if (dig_vld) begin
            acc_q <= acc_nx;
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               we     <= 1'b1;
               addr   <= wptr_q;
               wdata  <= acc_nx;
               wptr_q <= wptr_q + 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hexframe_loader.sv
module hexframe_loader #(
   parameter int WORD_W       = 16,
   parameter int ADDR_W       = 12,
   parameter bit ACCEPT_LOWER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   input  logic              eoi,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              load_done,
   output logic              load_err
);
   import hfl_pkg::*;

   initial begin
      if ((WORD_W % 4) != 0 || WORD_W < 8)
         $fatal(1, "hexframe_loader: WORD_W must be a multiple of 4 and at least 8");
      if (ADDR_W < 1)
         $fatal(1, "hexframe_loader: ADDR_W must be positive");
   end

   logic       step, is_hex, is_lb, is_rb, data_ok, inside_q, partial_d;
   logic [3:0] nib;
   frame_st_e  st_q, st_d;

   assign in_ready = !load_done;
   assign step     = in_valid && in_ready;

   hfl_char_decode #(.ACCEPT_LOWER(ACCEPT_LOWER)) u_dec (
      .ch(in_byte), .is_hex(is_hex), .nib(nib),
      .is_lbrace(is_lb), .is_rbrace(is_rb)
   );

   hfl_frame_tracker u_frm (
      .clk(clk), .rst_n(rst_n), .step(step),
      .is_lbrace(is_lb), .is_rbrace(is_rb),
      .st_q(st_q), .st_d(st_d), .inside_q(inside_q), .data_ok(data_ok)
   );

   hfl_word_packer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .dig_vld(data_ok && is_hex), .dig(nib),
      .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
      .partial_d(partial_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_done <= 1'b0;
         load_err  <= 1'b0;
      end else if (eoi && !load_done) begin
         load_done <= 1'b1;
         load_err  <= (st_d != FR_FINISHED) || partial_d;
      end
   end

endmodule

// File: rtl/hfl_checker.sv
module hfl_checker #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eoi,
   input logic              in_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              load_done,
   input logic              load_err,
   input logic              inside_q
);
   logic [ADDR_W-1:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      wr_cnt <= '0;
      else if (mem_we) wr_cnt <= wr_cnt + 1'b1;
   end

   assert_addr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == wr_cnt));

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   assert_eoi_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !load_done) |=> load_done);

   assert_no_ready_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> !in_ready);

   assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> load_done);

   assert_no_late_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && $past(load_done)) |-> !mem_we);

   assert_write_from_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(inside_q));

   assert_err_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && $past(load_done)) |-> $stable(load_err));

endmodule

bind hexframe_loader hfl_checker #(.ADDR_W(ADDR_W)) u_hfl_chk (
   .clk(clk), .rst_n(rst_n), .eoi(eoi), .in_ready(in_ready),
   .mem_we(mem_we), .mem_addr(mem_addr), .load_done(load_done),
   .load_err(load_err), .inside_q(inside_q)
);

// File: tb/tb_hexframe_loader.sv
module tb_hexframe_loader;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12;

   typedef struct packed {
      logic [191:0] txt;
      logic         err;
      logic [2:0]   nwords;
      logic [63:0]  words;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{txt: "xx{{7c01 0030}}yy",    err: 1'b0, nwords: 3'd2, words: 64'h7c01_0030_0000_0000},
      '{txt: "{{AbCd}}",             err: 1'b0, nwords: 3'd1, words: 64'habcd_0000_0000_0000},
      '{txt: "{{12345}}",            err: 1'b1, nwords: 3'd1, words: 64'h1234_0000_0000_0000},
      '{txt: "{{12 34",              err: 1'b1, nwords: 3'd1, words: 64'h1234_0000_0000_0000},
      '{txt: "noframe 1234",         err: 1'b1, nwords: 3'd0, words: 64'h0},
      '{txt: "{x{{1}2}3}4}}",        err: 1'b0, nwords: 3'd1, words: 64'h1234_0000_0000_0000},
      '{txt: "{{0f0F}}ab12",         err: 1'b0, nwords: 3'd1, words: 64'h0f0f_0000_0000_0000},
      '{txt: "{{}}",                 err: 1'b0, nwords: 3'd0, words: 64'h0},
      '{txt: "{{ g-h:zZ 9 }}",       err: 1'b1, nwords: 3'd0, words: 64'h0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_byte = 8'h00;
   logic              eoi = 1'b0;
   logic              in_ready, mem_we, load_done, load_err;
   logic [ADDR_W-1:0] mem_addr;
   logic [15:0]       mem_wdata;

   int nchecks = 0;
   int nfail = 0;
   logic [15:0] cap [16];
   int ncap = 0;
   bit addr_bad = 1'b0;

   hexframe_loader #(.WORD_W(16), .ADDR_W(ADDR_W), .ACCEPT_LOWER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .eoi(eoi), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .load_done(load_done), .load_err(load_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (int'(mem_addr) != ncap) addr_bad = 1'b1;
         if (ncap < 16) cap[ncap] = mem_wdata;
         ncap = ncap + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; eoi = 1'b0;
      @(negedge clk);
      @(negedge clk);
      ncap = 0; addr_bad = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic send_text(input logic [191:0] t);
      for (int i = 23; i >= 0; i--) begin
         if (t[i*8 +: 8] != 8'h00) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = t[i*8 +: 8];
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(load_done == 1'b0, "R1 done after reset", int'(load_done), 0);
      chk(load_err  == 1'b0, "R1 err after reset", int'(load_err), 0);
      chk(mem_we    == 1'b0, "R1 we after reset", int'(mem_we), 0);
      chk(in_ready  == 1'b1, "R1 ready after reset", int'(in_ready), 1);

      // table of images: R2 R3 R4 R5 R6 R8 R9
      for (int v = 0; v < NV; v++) begin
         do_reset();
         send_text(VECS[v].txt);
         pulse_eoi();
         chk(load_done == 1'b1, $sformatf("R7 vec%0d done", v), int'(load_done), 1);
         chk(load_err == VECS[v].err, $sformatf("R8/R9 vec%0d err", v),
             int'(load_err), int'(VECS[v].err));
         chk(ncap == int'(VECS[v].nwords), $sformatf("R6 vec%0d word count", v),
             ncap, int'(VECS[v].nwords));
         chk(!addr_bad, $sformatf("R5 vec%0d address order", v), int'(addr_bad), 0);
         for (int w = 0; w < int'(VECS[v].nwords); w++) begin
            chk(cap[w] == VECS[v].words[63-16*w -: 16],
                $sformatf("R3 R4 vec%0d word%0d", v, w),
                int'(cap[w]), int'(VECS[v].words[63-16*w -: 16]));
         end
      end

      // R4 write timing: strobe one cycle after fourth digit, one cycle wide
      do_reset();
      send_text({168'h0, "{{1"});
      @(negedge clk); in_valid = 1'b1; in_byte = "2";
      @(negedge clk); in_byte = "3";
      @(negedge clk); in_byte = "4";
      @(negedge clk); in_valid = 1'b0;
      chk(mem_we == 1'b1, "R4 strobe after fourth digit", int'(mem_we), 1);
      chk(mem_wdata == 16'h1234, "R4 packed value", int'(mem_wdata), 16'h1234);
      chk(mem_addr == '0, "R5 first address", int'(mem_addr), 0);
      @(negedge clk);
      chk(mem_we == 1'b0, "R4 strobe width", int'(mem_we), 0);

      // R8 eoi right after reset: no frame at all
      do_reset();
      @(negedge clk);
      pulse_eoi();
      chk(load_done == 1'b1, "R7 done on bare eoi", int'(load_done), 1);
      chk(load_err == 1'b1, "R8 error with no frame", int'(load_err), 1);

      // R7 R10 bytes and eoi after done are ignored
      chk(in_ready == 1'b0, "R7 ready low after done", int'(in_ready), 0);
      send_text({128'h0, "{{1234}}"});
      pulse_eoi();
      chk(ncap == 0, "R10 no write after done", ncap, 0);
      chk(load_done == 1'b1, "R7 done stays", int'(load_done), 1);
      chk(load_err == 1'b1, "R7 err unchanged", int'(load_err), 1);

      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

endmodule